// File: doc/BRIEF.md
# Serial Frame Length and Configuration Lock Guard

This block sits beside a byte-oriented SPI slave and checks two things. The first is whether each chip-select frame is well formed. The second is whether a command tries to change protected settings after the configuration has been locked. The serial lines are synchronised into the system clock. The block counts rising clock edges while chip select is low and judges the count when chip select returns high. The first byte of a frame is taken as the command. When the frame is well formed, that command is either passed on as accepted or refused with a write-error pulse.

A separate input marks a calibration measurement window. Any transition on the serial clock or data-in line inside that window is reported as a framing fault, because such activity would disturb the measurement. All fault outputs are one-cycle strobes meant for a sticky status latch elsewhere. Only an accepted mode write with its lock bit set can set the lock, and only reset clears it.

Top module: `spi_frame_guard`

## Requirements
- R1: When chip select (active low) rises after a frame whose count of serial-clock rising edges is nonzero and not a multiple of 8, `frame_err_o` pulses once and there is neither an accept pulse nor a write-error pulse.
- R2: A frame containing no serial-clock rising edge at all produces one `frame_err_o` pulse and no accept pulse.
- R3: A frame of 8·k bits (k ≥ 1), sampled MSB first on the rising serial-clock edge, produces no framing fault. If the command is not blocked, it produces one `accept_o` pulse with `accept_cmd_o` equal to the first byte. Any bytes after the first have no effect.
- R4: While locked, a command whose opcode (bits [7:5]) is 010 (mask A), 011 (mask B), 100 (mode) or 101 (deadtime) produces one `write_err_o` pulse and no accept pulse, so the protected setting is never delivered.
- R5: While locked, opcodes 110 and 111 also produce a write error and no accept. While unlocked, every opcode is accepted and no write error is raised.
- R6: An accepted mode command (opcode 100) with bit 0 set raises `lock_o`. The same command with bit 0 clear leaves the block unlocked. Opcodes 000 (read) and 001 (clear) stay accepted while locked. `lock_o` falls only on reset.
- R7: While `cal_window_i` is high, each transition of the serial clock or data-in line produces one `frame_err_o` pulse, whatever the state of chip select.
- R8: A malformed frame never produces a write error or an accept pulse, even when it is locked and carries a protected opcode.
- R9: Under reset, every output is low. Every fault and accept output is a single-cycle pulse for each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck_i | input | 1 | Serial clock, idles low, asynchronous |
| spi_cs_n_i | input | 1 | Chip select, active low, asynchronous |
| spi_mosi_i | input | 1 | Serial data in, asynchronous |
| cal_window_i | input | 1 | High while a calibration pulse is measured |
| frame_err_o | output | 1 | Framing-fault strobe |
| write_err_o | output | 1 | Locked-write strobe |
| accept_o | output | 1 | Command-accepted strobe |
| accept_cmd_o | output | 8 | Accepted command byte |
| lock_o | output | 1 | Configuration lock state |

## Verification
The bench builds the block with its default two-stage synchroniser and an 8-bit command. At this size it can sweep every frame length from 0 to 17 bits, which covers each remainder modulo 8 on both sides of a whole byte. It also covers all eight opcodes in both the unlocked and the locked state. The calibration window is then exercised with edges on each line separately, and reset is shown to be the only way out of the lock.

// File: rtl/frmguard_pkg.sv
package frmguard_pkg;

    localparam int CMD_W    = 8;
    localparam int OP_W     = 3;
    localparam int LOCK_POS = 0;
    localparam int PH_W     = $clog2(CMD_W);

    typedef enum logic [OP_W-1:0] {
        OP_READ     = 3'd0,
        OP_CLEAR    = 3'd1,
        OP_MASK_A   = 3'd2,
        OP_MASK_B   = 3'd3,
        OP_MODE     = 3'd4,
        OP_DEADTIME = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } op_e;

    typedef struct packed {
        logic             valid;
        logic             len_ok;
        logic [CMD_W-1:0] cmd;
    } frame_rpt_t;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } spi_lines_t;

    function automatic op_e op_of(input logic [CMD_W-1:0] cmd);
        return op_e'(cmd[CMD_W-1 -: OP_W]);
    endfunction

    function automatic logic op_allowed_locked(input op_e op);
        return (op == OP_READ) || (op == OP_CLEAR);
    endfunction

    function automatic logic wants_lock(input logic [CMD_W-1:0] cmd);
        return (op_of(cmd) == OP_MODE) && cmd[LOCK_POS];
    endfunction

endpackage

// File: rtl/frmguard_sync.sv
module frmguard_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/frmguard_frame_track.sv
module frmguard_frame_track
    import frmguard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  spi_lines_t lines_i,
    output frame_rpt_t rpt_o,
    output logic       sck_toggle_o,
    output logic       mosi_toggle_o
);

    spi_lines_t       prev_q;
    logic [PH_W-1:0]  phase_q;
    logic             seen_bit_q;
    logic             have_cmd_q;
    logic [CMD_W-1:0] shift_q;
    logic [CMD_W-1:0] cmd_q;

    logic             cs_start;
    logic             cs_end;
    logic             sck_rise;
    logic             in_frame;
    logic             byte_last;
    logic [CMD_W-1:0] shift_next;

    always_comb begin
        cs_start      = prev_q.cs_n && !lines_i.cs_n;
        cs_end        = !prev_q.cs_n && lines_i.cs_n;
        in_frame      = !prev_q.cs_n && !lines_i.cs_n;
        sck_rise      = in_frame && lines_i.sck && !prev_q.sck;
        byte_last     = (phase_q == PH_W'(CMD_W - 1));
        shift_next    = {shift_q[CMD_W-2:0], lines_i.mosi};
        sck_toggle_o  = lines_i.sck  != prev_q.sck;
        mosi_toggle_o = lines_i.mosi != prev_q.mosi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '{sck: 1'b0, cs_n: 1'b1, mosi: 1'b0};
        end else begin
            prev_q <= lines_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= '0;
            seen_bit_q <= 1'b0;
            have_cmd_q <= 1'b0;
            shift_q    <= '0;
            cmd_q      <= '0;
        end else if (cs_start) begin
            phase_q    <= '0;
            seen_bit_q <= 1'b0;
            have_cmd_q <= 1'b0;
            shift_q    <= '0;
        end else if (sck_rise) begin
            seen_bit_q <= 1'b1;
            shift_q    <= shift_next;
            phase_q    <= byte_last ? '0 : phase_q + 1'b1;
            if (byte_last && !have_cmd_q) begin
                cmd_q      <= shift_next;
                have_cmd_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rpt_o <= '0;
        end else begin
            rpt_o.valid  <= cs_end;
            rpt_o.len_ok <= cs_end && seen_bit_q && (phase_q == '0);
            rpt_o.cmd    <= cmd_q;
        end
    end

endmodule

// File: rtl/frmguard_cal_watch.sv
module frmguard_cal_watch (
    input  logic clk,
    input  logic rst,
    input  logic cal_window_i,
    input  logic sck_toggle_i,
    input  logic mosi_toggle_i,
    output logic cal_hit_o
);

    always_ff @(posedge clk) begin
        if (rst) cal_hit_o <= 1'b0;
        else     cal_hit_o <= cal_window_i && (sck_toggle_i || mosi_toggle_i);
    end

endmodule

// File: rtl/frmguard_cmd_guard.sv
module frmguard_cmd_guard
    import frmguard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  frame_rpt_t       rpt_i,
    input  logic             cal_hit_i,
    output logic             frame_err_o,
    output logic             write_err_o,
    output logic             accept_o,
    output logic [CMD_W-1:0] accept_cmd_o,
    output logic             lock_o
);

    logic good_frame;
    logic bad_frame;
    logic blocked;
    op_e  op;

    always_comb begin
        op         = op_of(rpt_i.cmd);
        good_frame = rpt_i.valid && rpt_i.len_ok;
        bad_frame  = rpt_i.valid && !rpt_i.len_ok;
        blocked    = lock_o && !op_allowed_locked(op);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_err_o  <= 1'b0;
            write_err_o  <= 1'b0;
            accept_o     <= 1'b0;
            accept_cmd_o <= '0;
            lock_o       <= 1'b0;
        end else begin
            frame_err_o <= bad_frame || cal_hit_i;
            write_err_o <= good_frame && blocked;
            accept_o    <= good_frame && !blocked;
            if (good_frame && !blocked) begin
                accept_cmd_o <= rpt_i.cmd;
                if (wants_lock(rpt_i.cmd)) lock_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_frame_guard.sv
module spi_frame_guard
    import frmguard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sck_i,
    input  logic             spi_cs_n_i,
    input  logic             spi_mosi_i,
    input  logic             cal_window_i,
    output logic             frame_err_o,
    output logic             write_err_o,
    output logic             accept_o,
    output logic [CMD_W-1:0] accept_cmd_o,
    output logic             lock_o
);

    spi_lines_t raw_lines;
    spi_lines_t sync_lines;
    frame_rpt_t frame_rpt;
    logic       sck_toggle;
    logic       mosi_toggle;
    logic       cal_hit;
    logic       frame_end_w;
    logic       frame_ok_w;

    assign raw_lines = '{sck: spi_sck_i, cs_n: spi_cs_n_i, mosi: spi_mosi_i};

    frmguard_sync #(
        .WIDTH   ($bits(spi_lines_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) i_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_lines),
        .q_o (sync_lines)
    );

    frmguard_frame_track i_track (
        .clk           (clk),
        .rst           (rst),
        .lines_i       (sync_lines),
        .rpt_o         (frame_rpt),
        .sck_toggle_o  (sck_toggle),
        .mosi_toggle_o (mosi_toggle)
    );

    frmguard_cal_watch i_cal (
        .clk           (clk),
        .rst           (rst),
        .cal_window_i  (cal_window_i),
        .sck_toggle_i  (sck_toggle),
        .mosi_toggle_i (mosi_toggle),
        .cal_hit_o     (cal_hit)
    );

    frmguard_cmd_guard i_guard (
        .clk          (clk),
        .rst          (rst),
        .rpt_i        (frame_rpt),
        .cal_hit_i    (cal_hit),
        .frame_err_o  (frame_err_o),
        .write_err_o  (write_err_o),
        .accept_o     (accept_o),
        .accept_cmd_o (accept_cmd_o),
        .lock_o       (lock_o)
    );

    assign frame_end_w = frame_rpt.valid;
    assign frame_ok_w  = frame_rpt.len_ok;

endmodule

// File: rtl/spi_frame_guard_chk.sv
module spi_frame_guard_chk
    import frmguard_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             frame_err_o,
    input logic             write_err_o,
    input logic             accept_o,
    input logic [CMD_W-1:0] accept_cmd_o,
    input logic             lock_o,
    input logic             frame_end_w,
    input logic             frame_ok_w,
    input logic             cal_hit
);

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_o |=> lock_o); // R6

    AST_WERR_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        write_err_o |-> $past(lock_o)); // R4

    AST_LOCKED_NO_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        accept_o |-> !($past(lock_o) && !op_allowed_locked(op_of(accept_cmd_o)))); // R5

    AST_BAD_FRAME_NO_ACTION: assert property (@(posedge clk) disable iff (rst)
        (write_err_o || accept_o) |-> $past(frame_end_w && frame_ok_w)); // R8

    AST_FERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        frame_err_o |-> $past((frame_end_w && !frame_ok_w) || cal_hit)); // R1

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $countones({write_err_o, accept_o}) <= 1); // R9

endmodule

bind spi_frame_guard spi_frame_guard_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_err_o  (frame_err_o),
    .write_err_o  (write_err_o),
    .accept_o     (accept_o),
    .accept_cmd_o (accept_cmd_o),
    .lock_o       (lock_o),
    .frame_end_w  (frame_end_w),
    .frame_ok_w   (frame_ok_w),
    .cal_hit      (cal_hit)
);

// File: tb/test_spi_frame_guard.sv
module test_spi_frame_guard;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       cal_en = 1'b0;
    logic       frame_err, write_err, accept, lock;
    logic [7:0] accept_cmd;

    int checks = 0;
    int errors = 0;
    int n_ferr = 0, n_werr = 0, n_acc = 0;
    logic [7:0] last_cmd = '0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_frame_guard i_spi_frame_guard (
        .clk          (clk),
        .rst          (rst),
        .spi_sck_i    (sck),
        .spi_cs_n_i   (cs_n),
        .spi_mosi_i   (mosi),
        .cal_window_i (cal_en),
        .frame_err_o  (frame_err),
        .write_err_o  (write_err),
        .accept_o     (accept),
        .accept_cmd_o (accept_cmd),
        .lock_o       (lock)
    );

    always @(negedge clk) begin
        if (frame_err) n_ferr++;
        if (write_err) n_werr++;
        if (accept) begin
            n_acc++;
            last_cmd = accept_cmd;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input int nbits, input logic [15:0] bits);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = bits[15-i];
            wait_clk(HALF);
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(12);
    endtask

    task automatic run_frame(input string req, input int nbits, input logic [15:0] bits,
                             input int e_ferr, input int e_werr, input int e_acc);
        int f0, w0, a0;
        f0 = n_ferr; w0 = n_werr; a0 = n_acc;
        send_frame(nbits, bits);
        check(req, "frame_err pulses", n_ferr - f0, e_ferr);
        check(req, "write_err pulses", n_werr - w0, e_werr);
        check(req, "accept pulses", n_acc - a0, e_acc);
        if (e_acc > 0) check(req, "accepted cmd", int'(last_cmd), int'(bits[15:8]));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
    endtask

    initial begin
        wait_clk(3);
        // R9: reset state
        check("R9", "frame_err at reset", int'(frame_err), 0);
        check("R9", "write_err at reset", int'(write_err), 0);
        check("R9", "accept at reset", int'(accept), 0);
        check("R9", "lock at reset", int'(lock), 0);
        rst = 1'b0;
        wait_clk(4);

        // R1 R2 R3: length sweep 0..17 with read opcode byte pattern
        for (int n = 0; n <= 17; n++) begin
            int bad;
            bad = (n == 0 || (n % 8) != 0) ? 1 : 0;
            if (n == 0)     run_frame("R2", n, 16'h1F_A5, 1, 0, 0);
            else if (bad==1) run_frame("R1", n, 16'h1F_A5, 1, 0, 0);
            else            run_frame("R3", n, 16'h1F_A5, 0, 0, 1);
        end
        // R3: second byte ignored
        run_frame("R3", 16, 16'h06_FF, 0, 0, 1);

        // R5: unlocked, every opcode accepted (bit0 clear keeps unlocked)
        for (int op = 0; op < 8; op++) begin
            logic [7:0] c;
            c = {op[2:0], 5'b10110};
            run_frame("R5", 8, {c, 8'h00}, 0, 0, 1);
        end
        check("R6", "lock after non-locking mode", int'(lock), 0);

        // R8: malformed lock request does nothing
        run_frame("R8", 7, 16'h81_00, 1, 0, 0);
        check("R8", "lock after bad frame", int'(lock), 0);

        // R6: lock request
        run_frame("R6", 8, 16'h81_00, 0, 0, 1);
        check("R6", "lock after lock request", int'(lock), 1);

        // R4 R5 R6: locked opcode sweep
        for (int op = 0; op < 8; op++) begin
            logic [7:0] c;
            c = {op[2:0], 5'b00000};
            if (op <= 1)      run_frame("R6", 8, {c, 8'h00}, 0, 0, 1);
            else if (op <= 5) run_frame("R4", 8, {c, 8'h00}, 0, 1, 0);
            else              run_frame("R5", 8, {c, 8'h00}, 0, 1, 0);
        end
        check("R6", "lock held", int'(lock), 1);

        // R8: malformed protected write while locked
        run_frame("R8", 11, 16'h40_00, 1, 0, 0);

        // R7: calibration window activity
        begin
            int f0;
            cal_en = 1'b1;
            wait_clk(6);
            f0 = n_ferr;
            for (int k = 0; k < 3; k++) begin
                sck = ~sck;
                wait_clk(8);
            end
            sck = 1'b0;
            wait_clk(8);
            check("R7", "cal sck edges", n_ferr - f0, 4);
            f0 = n_ferr;
            mosi = 1'b1;
            wait_clk(8);
            mosi = 1'b0;
            wait_clk(8);
            check("R7", "cal mosi edges", n_ferr - f0, 2);
            cal_en = 1'b0;
            wait_clk(6);
            f0 = n_ferr;
            sck = 1'b1; wait_clk(8); sck = 1'b0; wait_clk(8);
            check("R7", "edges outside window", n_ferr - f0, 0);
        end

        // R6: reset is the only exit from lock
        do_reset();
        check("R6", "lock after reset", int'(lock), 0);
        run_frame("R6", 8, 16'h4C_00, 0, 0, 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule